// File: doc/BRIEF.md
# Prefixed Instruction Stream Parser

This block sits after an instruction byte fetch and works out where each instruction starts and ends. It takes one byte per accepted handshake. From those bytes it picks out an optional addressing-mode prefix, zero, one or two opcode escape bytes, any displacement bytes that sit between an escape and the opcode, the opcode itself, and the immediate bytes after the opcode. It then assigns the instruction to one of four encoding formats.

When an instruction is complete, the parser holds one record on its outputs until the consumer takes it. It does not fetch the next byte while a record is pending. The record reports the format number, the prefix, the escape bytes, the displacement and its length, the opcode and the immediate value. The meaning of the opcode is left to later stages. Two side inputs shape the framing: one gives the displacement length in escape format 3, and one gives the immediate length of the current opcode.

Top module: `pfx_stream_parser`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1, and the parser expects the first byte of an instruction.
- R2: If the first byte is not a prefix (0xDD or 0xFD) and not an escape (0xCB or 0xED), that byte is the opcode. The same holds for the first byte after a prefix. The record then reports format 1 (out_fmt = 1).
- R3: A 0xDD or 0xFD byte counts as a prefix only as the very first byte. It sets out_has_pfx = 1 and out_pfx to that value. The same value in any later position is taken as an ordinary byte of its slot.
- R4: A 0xCB escape, either first or right after a prefix, gives format 3 (out_fmt = 3, out_esc0 = 0xCB). The displacement bytes come between the escape and the opcode. Their count is sampled when the escape is accepted. If disp_cnt is nonzero, the count is disp_cnt (1 to 3). If disp_cnt is zero, the count is 1 when a prefix was seen or disp_force is 1, and 0 otherwise. Displacement bytes are packed little-endian into out_disp, the first byte in bits 7:0.
- R5: A 0xED escape followed by 0xCB gives format 4 (out_fmt = 4, out_esc0 = 0xED, out_esc1 = 0xCB). The next byte is the opcode, with no displacement, even after a prefix.
- R6: A 0xED escape followed by any byte other than 0xCB gives format 2 (out_fmt = 2, out_esc0 = 0xED). That following byte is the opcode.
- R7: imm_cnt is sampled when the opcode is accepted and gives the number of immediate bytes that follow it. The value 3 counts as 2. Immediate bytes are packed little-endian into out_imm, the first byte in bits 7:0.
- R8: Once the last byte is accepted, out_valid is 1 from the next cycle. The record stays stable until a cycle with out_ready = 1. While it is pending, in_ready is 0 and input bytes are not taken.
- R9: A synchronous flush drops any partly parsed instruction and any pending record, and the parser goes back to expecting the first byte. A byte offered in the flush cycle is discarded.
- R10: Fields that an instruction does not use read as zero in its record: prefix, escape bytes, displacement, displacement count and immediate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop partial instruction and pending record |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Parser can take a byte |
| disp_force | input | 1 | Format 3 displacement present without prefix |
| disp_cnt | input | 2 | Directive displacement length, 0 = inactive |
| imm_cnt | input | 2 | Immediate length for the opcode being accepted |
| out_valid | output | 1 | Record valid |
| out_ready | input | 1 | Consumer takes record |
| out_fmt | output | 3 | Format number 1 to 4 |
| out_has_pfx | output | 1 | Prefix present |
| out_pfx | output | 8 | Prefix byte |
| out_esc0 | output | 8 | First escape byte |
| out_esc1 | output | 8 | Second escape byte |
| out_ndisp | output | 2 | Displacement byte count |
| out_disp | output | 24 | Displacement, little-endian |
| out_opc | output | 8 | Opcode byte |
| out_imm | output | 16 | Immediate, little-endian |

## Verification
Flush and byte acceptance can happen in the same cycle. The bench provokes this by asserting flush while a byte is offered halfway through a format 3 instruction. The verdict comes from the next record: the discarded byte must not appear in it, and the prefix and escape from before the flush must be gone. A second case asserts flush while a record is pending, and out_valid must fall in the following cycle instead of waiting for out_ready.

// File: rtl/pfx_stream_parser.sv
`timescale 1ns/1ps
module pfx_stream_parser #(
  parameter logic [7:0] PFX_X = 8'hDD,
  parameter logic [7:0] PFX_Y = 8'hFD,
  parameter logic [7:0] ESC_B = 8'hCB,
  parameter logic [7:0] ESC_E = 8'hED,
  parameter int         DBYT  = 3,
  parameter int         IBYT  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                in_valid,
  input  logic [7:0]          in_data,
  output logic                in_ready,
  input  logic                disp_force,
  input  logic [1:0]          disp_cnt,
  input  logic [1:0]          imm_cnt,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [2:0]          out_fmt,
  output logic                out_has_pfx,
  output logic [7:0]          out_pfx,
  output logic [7:0]          out_esc0,
  output logic [7:0]          out_esc1,
  output logic [1:0]          out_ndisp,
  output logic [8*DBYT-1:0]   out_disp,
  output logic [7:0]          out_opc,
  output logic [8*IBYT-1:0]   out_imm
);
  localparam int DW = 8 * DBYT;
  localparam int IW = 8 * IBYT;

  typedef enum logic [2:0] {S_HEAD, S_POST, S_ESCX, S_DISP, S_OPC, S_IMM, S_DONE} st_t;
  st_t st;

  logic [1:0] dleft, didx, ileft;
  logic       iidx;
  logic       take, is_pfx;
  logic [1:0] nd, ic;

  assign in_ready  = (st != S_DONE);
  assign out_valid = (st == S_DONE);
  assign take      = in_valid && in_ready && !flush;
  assign is_pfx    = (in_data == PFX_X) || (in_data == PFX_Y);
  assign nd        = (disp_cnt != 2'd0) ? disp_cnt
                   : ((out_has_pfx || disp_force) ? 2'd1 : 2'd0);
  assign ic        = (imm_cnt == 2'd3) ? 2'd2 : imm_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || flush || (st == S_DONE && out_ready)) begin
      st <= S_HEAD;
      out_fmt <= 3'd0; out_has_pfx <= 1'b0; out_pfx <= 8'h00;
      out_esc0 <= 8'h00; out_esc1 <= 8'h00; out_ndisp <= 2'd0;
      out_disp <= '0; out_opc <= 8'h00; out_imm <= '0;
      dleft <= 2'd0; didx <= 2'd0; ileft <= 2'd0; iidx <= 1'b0;
    end else if (take) begin
      case (st)
        S_HEAD, S_POST: begin
          if (st == S_HEAD && is_pfx) begin
            out_has_pfx <= 1'b1;
            out_pfx     <= in_data;
            st          <= S_POST;
          end else if (in_data == ESC_B) begin
            out_fmt   <= 3'd3;
            out_esc0  <= in_data;
            out_ndisp <= nd;
            dleft     <= nd;
            st        <= (nd != 2'd0) ? S_DISP : S_OPC;
          end else if (in_data == ESC_E) begin
            out_esc0 <= in_data;
            st       <= S_ESCX;
          end else begin
            out_fmt <= 3'd1;
            out_opc <= in_data;
            ileft   <= ic;
            st      <= (ic != 2'd0) ? S_IMM : S_DONE;
          end
        end
        S_ESCX: begin
          if (in_data == ESC_B) begin
            out_fmt  <= 3'd4;
            out_esc1 <= in_data;
            st       <= S_OPC;
          end else begin
            out_fmt <= 3'd2;
            out_opc <= in_data;
            ileft   <= ic;
            st      <= (ic != 2'd0) ? S_IMM : S_DONE;
          end
        end
        S_DISP: begin
          out_disp[{didx, 3'b000} +: 8] <= in_data;
          didx  <= didx + 2'd1;
          dleft <= dleft - 2'd1;
          if (dleft == 2'd1) st <= S_OPC;
        end
        S_OPC: begin
          out_opc <= in_data;
          ileft   <= ic;
          st      <= (ic != 2'd0) ? S_IMM : S_DONE;
        end
        S_IMM: begin
          out_imm[{iidx, 3'b000} +: 8] <= in_data;
          iidx  <= ~iidx;
          ileft <= ileft - 2'd1;
          if (ileft == 2'd1) st <= S_DONE;
        end
        default: st <= st;
      endcase
    end
  end
endmodule

// File: rtl/pfx_stream_parser_chk.sv
`timescale 1ns/1ps
module pfx_stream_parser_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        flush,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [2:0]  out_fmt,
  input logic        out_has_pfx,
  input logic [7:0]  out_pfx,
  input logic [7:0]  out_esc0,
  input logic [7:0]  out_esc1,
  input logic [1:0]  out_ndisp,
  input logic [23:0] out_disp,
  input logic [7:0]  out_opc,
  input logic [15:0] out_imm
);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !flush |=> out_valid && $stable(out_fmt) && $stable(out_opc)
      && $stable(out_disp) && $stable(out_imm) && $stable(out_pfx));
  a_r8_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);
  a_r2_fmt_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_fmt >= 3'd1) && (out_fmt <= 3'd4));
  a_r5_esc_pair: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fmt == 3'd4 |-> out_esc0 == 8'hED && out_esc1 == 8'hCB);
  a_r4_disp_f3_only: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fmt != 3'd3 |-> out_ndisp == 2'd0 && out_disp == 24'h0);
  a_r10_no_pfx_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_has_pfx |-> out_pfx == 8'h00);
endmodule

bind pfx_stream_parser pfx_stream_parser_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_fmt(out_fmt),
  .out_has_pfx(out_has_pfx), .out_pfx(out_pfx), .out_esc0(out_esc0),
  .out_esc1(out_esc1), .out_ndisp(out_ndisp), .out_disp(out_disp),
  .out_opc(out_opc), .out_imm(out_imm)
);

// File: tb/tb_pfx_stream_parser.sv
`timescale 1ns/1ps
module tb_pfx_stream_parser;
  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic in_valid = 1'b0, disp_force = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic [1:0] disp_cnt = 2'd0, imm_cnt = 2'd0;
  logic in_ready, out_valid, out_has_pfx;
  logic [2:0] out_fmt;
  logic [7:0] out_pfx, out_esc0, out_esc1, out_opc;
  logic [1:0] out_ndisp;
  logic [23:0] out_disp;
  logic [15:0] out_imm;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  pfx_stream_parser dut (.*);

  task automatic chk(string req, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk); in_valid = 1'b1; in_data = b;
    @(posedge clk); #1; in_valid = 1'b0;
  endtask

  // record layout: valid, fmt, has_pfx, pfx, esc0, esc1, ndisp, disp, opc, imm
  task automatic expect_rec(string req, logic [2:0] f, logic hp, logic [7:0] p, logic [7:0] e0,
                            logic [7:0] e1, logic [1:0] nd, logic [23:0] d, logic [7:0] o,
                            logic [15:0] im);
    @(negedge clk);
    chk(req, {17'd0, out_valid, out_fmt, out_has_pfx, out_pfx, out_esc0, out_esc1, out_ndisp,
              out_disp, out_opc, out_imm},
             {17'd0, 1'b1, f, hp, p, e0, e1, nd, d, o, im});
    out_ready = 1'b1;
    @(posedge clk); #1; out_ready = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 reset", {94'd0, out_valid, in_ready}, {94'd0, 2'b01});
  endtask

  task automatic t_fmt1;
    send(8'h46);
    expect_rec("R2/R10 plain opcode", 3'd1, 0, 0, 0, 0, 0, 0, 8'h46, 0);
  endtask

  task automatic t_prefix;
    send(8'hDD); send(8'h46);
    expect_rec("R3 DD prefix", 3'd1, 1, 8'hDD, 0, 0, 0, 0, 8'h46, 0);
    send(8'hFD); send(8'hDD);
    expect_rec("R3 second prefix value is opcode", 3'd1, 1, 8'hFD, 0, 0, 0, 0, 8'hDD, 0);
  endtask

  task automatic t_fmt3;
    send(8'hCB); send(8'h06);
    expect_rec("R4 no displacement", 3'd3, 0, 0, 8'hCB, 0, 0, 0, 8'h06, 0);
    send(8'hDD); send(8'hCB); send(8'h05); send(8'h06);
    expect_rec("R4 prefix displacement", 3'd3, 1, 8'hDD, 8'hCB, 0, 1, 24'h05, 8'h06, 0);
    disp_force = 1'b1;
    send(8'hCB); disp_force = 1'b0; send(8'h7F); send(8'h11);
    expect_rec("R4 forced displacement", 3'd3, 0, 0, 8'hCB, 0, 1, 24'h7F, 8'h11, 0);
    disp_cnt = 2'd3;
    send(8'hCB); disp_cnt = 2'd0;
    send(8'h01); send(8'h02); send(8'h03); send(8'h26);
    expect_rec("R4 directive three bytes", 3'd3, 0, 0, 8'hCB, 0, 3, 24'h030201, 8'h26, 0);
  endtask

  task automatic t_fmt4;
    imm_cnt = 2'd2;
    send(8'hED); send(8'hCB); send(8'h01);
    imm_cnt = 2'd0;
    send(8'h34); send(8'h12);
    expect_rec("R5 escape pair with word", 3'd4, 0, 0, 8'hED, 8'hCB, 0, 0, 8'h01, 16'h1234);
    send(8'hDD); send(8'hED); send(8'hCB); send(8'h07);
    expect_rec("R5 prefix no displacement", 3'd4, 1, 8'hDD, 8'hED, 8'hCB, 0, 0, 8'h07, 0);
  endtask

  task automatic t_fmt2;
    send(8'hED); send(8'h44);
    expect_rec("R6 single escape", 3'd2, 0, 0, 8'hED, 0, 0, 0, 8'h44, 0);
    send(8'hED); send(8'hED);
    expect_rec("R6 escape value as opcode", 3'd2, 0, 0, 8'hED, 0, 0, 0, 8'hED, 0);
  endtask

  task automatic t_imm;
    imm_cnt = 2'd1;
    send(8'h3E); imm_cnt = 2'd0; send(8'hAB);
    expect_rec("R7 sampled with opcode", 3'd1, 0, 0, 0, 0, 0, 0, 8'h3E, 16'h00AB);
    imm_cnt = 2'd3;
    send(8'h21); imm_cnt = 2'd0; send(8'hCD); send(8'hAB);
    expect_rec("R7 count 3 acts as 2", 3'd1, 0, 0, 0, 0, 0, 0, 8'h21, 16'hABCD);
  endtask

  task automatic t_hold;
    send(8'h55);
    repeat (3) begin
      @(negedge clk); in_valid = 1'b1; in_data = 8'h99;
    end
    @(negedge clk);
    chk("R8 pending holds", {78'd0, out_valid, in_ready, out_opc, out_fmt, 5'd0},
                            {78'd0, 1'b1, 1'b0, 8'h55, 3'd1, 5'd0});
    in_valid = 1'b0;
    expect_rec("R8 record after stall", 3'd1, 0, 0, 0, 0, 0, 0, 8'h55, 0);
    send(8'h46);
    expect_rec("R8 stalled byte not taken", 3'd1, 0, 0, 0, 0, 0, 0, 8'h46, 0);
  endtask

  task automatic t_flush;
    send(8'hDD); send(8'hCB);
    @(negedge clk); flush = 1'b1; in_valid = 1'b1; in_data = 8'h77;
    @(posedge clk); #1; flush = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    chk("R9 flush idle", {94'd0, out_valid, in_ready}, {94'd0, 2'b01});
    send(8'h46);
    expect_rec("R9 clean after flush", 3'd1, 0, 0, 0, 0, 0, 0, 8'h46, 0);
    send(8'h12);
    @(negedge clk); flush = 1'b1;
    @(posedge clk); #1; flush = 1'b0;
    @(negedge clk);
    chk("R9 pending dropped", {94'd0, out_valid, in_ready}, {94'd0, 2'b01});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_fmt1();
    t_prefix();
    t_fmt3();
    t_fmt4();
    t_fmt2();
    t_imm();
    t_hold();
    t_flush();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule